// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block supervises software liveness against a free-running 64-bit system count supplied from outside. Software programs a tick interval, sets the enable bit, and must then write to a separate refresh frame before that interval runs out. If the interval runs out once, the block raises an interrupt and arms a second interval of the same length. If that second interval also runs out without a refresh, the block raises a reset request.

Two independent 4 KiB register frames are exposed, each on its own simple 32-bit register port. The control frame holds enable and stage status, the interval, and the current deadline (as two words). The refresh frame holds only the refresh register. Both frames carry a fixed identification word. Read data is combinational on the selected address. A write takes effect at the clock edge on which it is presented.

Top module: `staged_wdog`

## Requirements
- R1: After reset both outputs are low, and the control/status, interval and deadline registers all read 0.
- R2: Control/status is at control offset 0x000. Bit 0 is enable and can be read and written. Bit 1 (first-stage flag) and bit 2 (second-stage flag) are read-only, and writes to them are ignored. All other bits read 0.
- R3: The interval register is at control offset 0x008 and is 32 bits wide, readable and writable. It holds the tick count of each stage.
- R4: The 64-bit deadline is read-only. Its low word is at control offset 0x010 and its high word at 0x014.
- R5: Three events restart the timeout: a write to the interval register, a refresh write, or a control write that takes enable from 0 to 1. A restart clears both stage flags and loads the deadline with the count at that edge plus the interval. For an interval write, the newly written interval is used.
- R6: While enabled, with the first-stage flag clear, an edge where count >= deadline sets the first-stage flag. The interrupt output goes high after that edge, and the deadline is reloaded with that count plus the interval.
- R7: While enabled, with the first-stage flag set, an edge where count >= deadline sets the second-stage flag and raises the reset request. Both flags and both outputs stay high until a restart or a disable.
- R8: The refresh register is at refresh offset 0x000. A write to it restarts the timeout whatever the data, and the register reads 0.
- R9: A control write with bit 0 = 0 disables the block and clears both flags. While disabled, both outputs stay low and no expiry occurs.
- R10: Offset 0xFCC in both frames reads the IMPL_ID parameter.
- R11: Any other offset in either frame reads 0, and writes to it change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_count | input | CNT_W | Free-running system count |
| ctl_sel | input | 1 | Control frame select |
| ctl_we | input | 1 | Control frame write (1) / read (0) |
| ctl_addr | input | ADDR_W | Control frame byte offset |
| ctl_wdata | input | DATA_W | Control frame write data |
| ctl_rdata | output | DATA_W | Control frame read data (0 when not reading) |
| rfr_sel | input | 1 | Refresh frame select |
| rfr_we | input | 1 | Refresh frame write (1) / read (0) |
| rfr_addr | input | ADDR_W | Refresh frame byte offset |
| rfr_wdata | input | DATA_W | Refresh frame write data (ignored) |
| rfr_rdata | output | DATA_W | Refresh frame read data (0 when not reading) |
| wd_irq | output | 1 | First-stage interrupt |
| wd_rst_req | output | 1 | Second-stage reset request |

## Verification
The bound checker watches several relations on every cycle:
- the reset request never appears without the interrupt, and only rises after the interrupt was already high;
- both outputs stay low while disabled;
- a refresh or a disable drops both outputs on the next cycle;
- a refresh loads the deadline from the count plus the interval;
- an interrupt only rises after the count reached the deadline;
- unmapped control reads return zero.

Only the bench scenarios show the exact expiry cycles of both stages and the deadline values read back across a 32-bit carry. They also show that writes to the status bits and to unmapped offsets change nothing, that a steady refresh holds off expiry, and that the timer stays frozen across a long disabled span.

// File: rtl/stgwd_pkg.sv
package stgwd_pkg;
   localparam int FRAME_AW = 12;

   localparam logic [FRAME_AW-1:0] OFS_CTRL_STAT = 12'h000;
   localparam logic [FRAME_AW-1:0] OFS_INTERVAL  = 12'h008;
   localparam logic [FRAME_AW-1:0] OFS_DUE_LO    = 12'h010;
   localparam logic [FRAME_AW-1:0] OFS_DUE_HI    = 12'h014;
   localparam logic [FRAME_AW-1:0] OFS_KICK      = 12'h000;
   localparam logic [FRAME_AW-1:0] OFS_IDENT     = 12'hFCC;

   typedef struct packed {
      logic stage2;
      logic stage1;
      logic enable;
   } wd_stat_t;
endpackage

// File: rtl/stgwd_ctl_frame.sv
module stgwd_ctl_frame
   import stgwd_pkg::*;
#(
   parameter int          ADDR_W  = 12,
   parameter int          DATA_W  = 32,
   parameter int          CNT_W   = 64,
   parameter int          OFS_W   = 32,
   parameter logic [31:0] IMPL_ID = 32'h5A17_0B01
) (
   input  logic              sel_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  wd_stat_t          stat_i,
   input  logic [OFS_W-1:0]  interval_i,
   input  logic [CNT_W-1:0]  due_i,
   output logic              stat_wr_o,
   output logic              interval_wr_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] due_lo, due_hi;
   logic              rd;

   assign due_lo = due_i[DATA_W-1:0];

   generate
      if (CNT_W > DATA_W) begin : g_wide_due
         assign due_hi = DATA_W'(due_i[CNT_W-1:DATA_W]);
      end else begin : g_narrow_due
         assign due_hi = '0;
      end
   endgenerate

   assign stat_wr_o     = sel_i & we_i & (addr_i == ADDR_W'(OFS_CTRL_STAT));
   assign interval_wr_o = sel_i & we_i & (addr_i == ADDR_W'(OFS_INTERVAL));
   assign rd            = sel_i & ~we_i;

   always_comb begin
      rdata_o = '0;
      if (rd) begin
         if (addr_i == ADDR_W'(OFS_CTRL_STAT))
            rdata_o = DATA_W'({stat_i.stage2, stat_i.stage1, stat_i.enable});
         else if (addr_i == ADDR_W'(OFS_INTERVAL))
            rdata_o = DATA_W'(interval_i);
         else if (addr_i == ADDR_W'(OFS_DUE_LO))
            rdata_o = due_lo;
         else if (addr_i == ADDR_W'(OFS_DUE_HI))
            rdata_o = due_hi;
         else if (addr_i == ADDR_W'(OFS_IDENT))
            rdata_o = DATA_W'(IMPL_ID);
      end
   end
endmodule

// File: rtl/stgwd_rfr_frame.sv
module stgwd_rfr_frame
   import stgwd_pkg::*;
#(
   parameter int          ADDR_W  = 12,
   parameter int          DATA_W  = 32,
   parameter logic [31:0] IMPL_ID = 32'h5A17_0B01
) (
   input  logic              sel_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              kick_o,
   output logic [DATA_W-1:0] rdata_o
);
   assign kick_o = sel_i & we_i & (addr_i == ADDR_W'(OFS_KICK));

   always_comb begin
      rdata_o = '0;
      if (sel_i && !we_i && addr_i == ADDR_W'(OFS_IDENT))
         rdata_o = DATA_W'(IMPL_ID);
   end
endmodule

// File: rtl/stgwd_engine.sv
module stgwd_engine
   import stgwd_pkg::*;
#(
   parameter int CNT_W = 64,
   parameter int OFS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic             stat_wr_i,
   input  logic             en_wdata_i,
   input  logic             interval_wr_i,
   input  logic [OFS_W-1:0] interval_wdata_i,
   input  logic             kick_i,
   output wd_stat_t         stat_o,
   output logic [OFS_W-1:0] interval_o,
   output logic [CNT_W-1:0] due_o,
   output logic             irq_o,
   output logic             rst_req_o
);
   logic             en_q, s1_q, s2_q;
   logic [OFS_W-1:0] ivl_q, ivl_nx;
   logic [CNT_W-1:0] due_q, reload;
   logic             en_rise, en_fall, restart, hit;

   assign en_rise = stat_wr_i & en_wdata_i & ~en_q;
   assign en_fall = stat_wr_i & ~en_wdata_i;
   assign ivl_nx  = interval_wr_i ? interval_wdata_i : ivl_q;
   assign restart = kick_i | interval_wr_i | en_rise;
   assign reload  = count_i + CNT_W'(ivl_nx);
   assign hit     = en_q & (count_i >= due_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         s1_q  <= 1'b0;
         s2_q  <= 1'b0;
         ivl_q <= '0;
         due_q <= '0;
      end else begin
         ivl_q <= ivl_nx;
         if (stat_wr_i)
            en_q <= en_wdata_i;
         if (en_fall) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
         end else if (restart) begin
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            due_q <= reload;
         end else if (hit) begin
            if (!s1_q) begin
               s1_q  <= 1'b1;
               due_q <= reload;
            end else begin
               s2_q <= 1'b1;
            end
         end
      end
   end

   assign stat_o     = '{stage2: s2_q, stage1: s1_q, enable: en_q};
   assign interval_o = ivl_q;
   assign due_o      = due_q;
   assign irq_o      = en_q & s1_q;
   assign rst_req_o  = en_q & s2_q;
endmodule

// File: rtl/staged_wdog.sv
module staged_wdog
   import stgwd_pkg::*;
#(
   parameter int          ADDR_W  = 12,
   parameter int          DATA_W  = 32,
   parameter int          CNT_W   = 64,
   parameter int          OFS_W   = 32,
   parameter logic [31:0] IMPL_ID = 32'h5A17_0B01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  sys_count,
   input  logic              ctl_sel,
   input  logic              ctl_we,
   input  logic [ADDR_W-1:0] ctl_addr,
   input  logic [DATA_W-1:0] ctl_wdata,
   output logic [DATA_W-1:0] ctl_rdata,
   input  logic              rfr_sel,
   input  logic              rfr_we,
   input  logic [ADDR_W-1:0] rfr_addr,
   input  logic [DATA_W-1:0] rfr_wdata,
   output logic [DATA_W-1:0] rfr_rdata,
   output logic              wd_irq,
   output logic              wd_rst_req
);
   generate
      if (ADDR_W < FRAME_AW)  begin : g_chk_aw  $error("ADDR_W must cover a 4 KiB frame"); end
      if (DATA_W < 32)        begin : g_chk_dw  $error("DATA_W must be at least 32"); end
      if (OFS_W > DATA_W)     begin : g_chk_ow  $error("OFS_W must fit in one data word"); end
      if (CNT_W < DATA_W || CNT_W > 2*DATA_W)
                              begin : g_chk_cw  $error("CNT_W must span one or two data words"); end
   endgenerate

   wd_stat_t         stat;
   logic [OFS_W-1:0] interval;
   logic [CNT_W-1:0] due;
   logic             stat_wr, interval_wr, kick;
   logic [DATA_W-1:0] rfr_unused;

   assign rfr_unused = rfr_wdata;

   stgwd_ctl_frame #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .OFS_W(OFS_W), .IMPL_ID(IMPL_ID)
   ) u_ctl (
      .sel_i(ctl_sel), .we_i(ctl_we), .addr_i(ctl_addr),
      .stat_i(stat), .interval_i(interval), .due_i(due),
      .stat_wr_o(stat_wr), .interval_wr_o(interval_wr), .rdata_o(ctl_rdata)
   );

   stgwd_rfr_frame #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_ID(IMPL_ID)
   ) u_rfr (
      .sel_i(rfr_sel), .we_i(rfr_we), .addr_i(rfr_addr),
      .kick_o(kick), .rdata_o(rfr_rdata)
   );

   stgwd_engine #(
      .CNT_W(CNT_W), .OFS_W(OFS_W)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .count_i(sys_count),
      .stat_wr_i(stat_wr), .en_wdata_i(ctl_wdata[0]),
      .interval_wr_i(interval_wr), .interval_wdata_i(ctl_wdata[OFS_W-1:0]),
      .kick_i(kick),
      .stat_o(stat), .interval_o(interval), .due_o(due),
      .irq_o(wd_irq), .rst_req_o(wd_rst_req)
   );
endmodule

// File: rtl/staged_wdog_chk.sv
module staged_wdog_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64,
   parameter int OFS_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wd_irq,
   input logic              wd_rst_req,
   input logic              en,
   input logic              kick,
   input logic              interval_wr,
   input logic              stat_wr,
   input logic              wdata_en,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  due,
   input logic [OFS_W-1:0]  interval,
   input logic              ctl_sel,
   input logic              ctl_we,
   input logic [ADDR_W-1:0] ctl_addr,
   input logic [DATA_W-1:0] ctl_rdata
);
   logic ctl_mapped;
   assign ctl_mapped = (ctl_addr == ADDR_W'(12'h000)) || (ctl_addr == ADDR_W'(12'h008)) ||
                       (ctl_addr == ADDR_W'(12'h010)) || (ctl_addr == ADDR_W'(12'h014)) ||
                       (ctl_addr == ADDR_W'(12'hFCC));

   p_rst_implies_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst_req |-> wd_irq);

   p_rst_after_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_rst_req) |-> $past(wd_irq));

   p_quiet_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!wd_irq && !wd_rst_req));

   p_disable_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !wdata_en) |=> (!wd_irq && !wd_rst_req));

   p_kick_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (!wd_irq && !wd_rst_req));

   p_kick_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kick && !interval_wr && !(stat_wr && !wdata_en)) |=>
         (due == $past(count) + CNT_W'($past(interval))));

   p_irq_on_deadline_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_irq) |-> ($past(count) >= $past(due)));

   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_sel && !ctl_we && !ctl_mapped) |-> (ctl_rdata == '0));
endmodule

bind staged_wdog staged_wdog_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .OFS_W(OFS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wd_irq(wd_irq), .wd_rst_req(wd_rst_req),
   .en(stat.enable), .kick(kick), .interval_wr(interval_wr),
   .stat_wr(stat_wr), .wdata_en(ctl_wdata[0]),
   .count(sys_count), .due(due), .interval(interval),
   .ctl_sel(ctl_sel), .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_rdata(ctl_rdata)
);

// File: tb/staged_wdog_tb.sv
`timescale 1ns/1ps
module staged_wdog_tb;
   localparam logic [31:0] ID = 32'h5A17_0B01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cnt = 64'h1_FFFF_FFA0;
   logic        ctl_sel = 0, ctl_we = 0, rfr_sel = 0, rfr_we = 0;
   logic [11:0] ctl_addr = '0, rfr_addr = '0;
   logic [31:0] ctl_wdata = '0, rfr_wdata = '0;
   logic [31:0] ctl_rdata, rfr_rdata;
   logic        wd_irq, wd_rst_req;
   int          n_run = 0, n_fail = 0;

   always #5 clk = ~clk;
   always @(negedge clk) cnt <= cnt + 64'd1;

   staged_wdog #(.IMPL_ID(ID)) u_dut (
      .clk(clk), .rst_n(rst_n), .sys_count(cnt),
      .ctl_sel(ctl_sel), .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata),
      .rfr_sel(rfr_sel), .rfr_we(rfr_we), .rfr_addr(rfr_addr), .rfr_wdata(rfr_wdata),
      .rfr_rdata(rfr_rdata),
      .wd_irq(wd_irq), .wd_rst_req(wd_rst_req)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic ctl_write(input logic [11:0] a, input logic [31:0] d, output logic [63:0] at);
      step();
      ctl_sel = 1; ctl_we = 1; ctl_addr = a; ctl_wdata = d;
      @(posedge clk); at = cnt;
      step();
      ctl_sel = 0; ctl_we = 0;
   endtask

   task automatic rfr_write(input logic [11:0] a, input logic [31:0] d, output logic [63:0] at);
      step();
      rfr_sel = 1; rfr_we = 1; rfr_addr = a; rfr_wdata = d;
      @(posedge clk); at = cnt;
      step();
      rfr_sel = 0; rfr_we = 0;
   endtask

   task automatic ctl_read(input logic [11:0] a, output logic [31:0] d);
      ctl_sel = 1; ctl_we = 0; ctl_addr = a;
      #0.1; d = ctl_rdata;
      ctl_sel = 0;
      #0.1;
   endtask

   task automatic rfr_read(input logic [11:0] a, output logic [31:0] d);
      rfr_sel = 1; rfr_we = 0; rfr_addr = a;
      #0.1; d = rfr_rdata;
      rfr_sel = 0;
      #0.1;
   endtask

   task automatic wait_to(input logic [63:0] target);
      while (cnt < target) step();
   endtask

   task automatic chk_due(input string tag, input logic [63:0] exp);
      logic [31:0] lo, hi;
      ctl_read(12'h010, lo);
      ctl_read(12'h014, hi);
      chk(tag, {hi, lo}, exp);
   endtask

   logic [63:0] due_exp;

   task automatic t_reset();
      logic [31:0] d;
      step();
      chk("R1 irq after reset", 64'(wd_irq), 0);
      chk("R1 rst_req after reset", 64'(wd_rst_req), 0);
      ctl_read(12'h000, d); chk("R1 ctrl after reset", 64'(d), 0);
      ctl_read(12'h008, d); chk("R1 interval after reset", 64'(d), 0);
      chk_due("R1 deadline after reset", 0);
      ctl_read(12'hFCC, d); chk("R10 control ident", 64'(d), 64'(ID));
      rfr_read(12'hFCC, d); chk("R10 refresh ident", 64'(d), 64'(ID));
   endtask

   task automatic t_unmapped_ro();
      logic [31:0] d;
      logic [63:0] at;
      ctl_write(12'h004, 32'hFFFF_FFFF, at);
      ctl_write(12'h00C, 32'hFFFF_FFFF, at);
      ctl_read(12'h004, d); chk("R11 unmapped read", 64'(d), 0);
      ctl_read(12'h008, d); chk("R11 interval untouched", 64'(d), 0);
      ctl_read(12'h000, d); chk("R11 ctrl untouched", 64'(d), 0);
      ctl_write(12'h000, 32'h0000_0006, at);
      ctl_read(12'h000, d); chk("R2 status bits ignore writes", 64'(d), 0);
      rfr_read(12'h000, d); chk("R8 refresh reg reads zero", 64'(d), 0);
      rfr_read(12'h100, d); chk("R11 refresh unmapped read", 64'(d), 0);
      chk("R2 no output from status write", 64'({wd_irq, wd_rst_req}), 0);
   endtask

   task automatic t_two_stage();
      logic [31:0] d;
      logic [63:0] at;
      ctl_write(12'h008, 32'd20, at);
      ctl_read(12'h008, d); chk("R3 interval readback", 64'(d), 20);
      ctl_write(12'h000, 32'h1, at);
      due_exp = at + 64'd20;
      chk_due("R5 R4 deadline on enable", due_exp);
      ctl_read(12'h000, d); chk("R2 enable readback", 64'(d), 1);
      wait_to(due_exp);
      chk("R6 irq low before deadline", 64'(wd_irq), 0);
      step();
      chk("R6 irq high after deadline", 64'(wd_irq), 1);
      ctl_read(12'h000, d); chk("R6 ctrl stage1", 64'(d), 3);
      due_exp = due_exp + 64'd20;
      chk_due("R6 deadline reload", due_exp);
      wait_to(due_exp);
      chk("R7 rst_req low before 2nd deadline", 64'(wd_rst_req), 0);
      step();
      chk("R7 rst_req high after 2nd deadline", 64'(wd_rst_req), 1);
      ctl_read(12'h000, d); chk("R7 ctrl stage2", 64'(d), 7);
      repeat (30) step();
      chk("R7 outputs sticky", 64'({wd_irq, wd_rst_req}), 64'b11);
      ctl_write(12'h000, 32'h7, at);
      ctl_read(12'h000, d); chk("R2 rewrite enable keeps flags", 64'(d), 7);
   endtask

   task automatic t_refresh();
      logic [31:0] d;
      logic [63:0] at;
      logic        seen;
      rfr_write(12'h000, 32'hDEAD_BEEF, at);
      chk("R8 refresh clears outputs", 64'({wd_irq, wd_rst_req}), 0);
      ctl_read(12'h000, d); chk("R8 refresh clears flags", 64'(d), 1);
      chk_due("R5 refresh deadline", at + 64'd20);
      seen = 0;
      for (int i = 0; i < 6; i++) begin
         repeat (8) begin step(); seen = seen | wd_irq; end
         rfr_write(12'h000, 32'(i), at);
      end
      chk("R8 steady refresh prevents expiry", 64'(seen), 0);
      due_exp = at + 64'd20;
      wait_to(due_exp);
      step();
      chk("R6 expiry after last refresh", 64'(wd_irq), 1);
   endtask

   task automatic t_interval_restart();
      logic [63:0] at;
      ctl_write(12'h008, 32'd50, at);
      chk("R5 interval write clears irq", 64'(wd_irq), 0);
      due_exp = at + 64'd50;
      chk_due("R5 interval write uses new value", due_exp);
   endtask

   task automatic t_disable();
      logic [31:0] d;
      logic [63:0] at;
      logic        seen;
      wait_to(due_exp);
      step();
      chk("R6 irq before disable", 64'(wd_irq), 1);
      ctl_write(12'h000, 32'h0, at);
      chk("R9 disable drops outputs", 64'({wd_irq, wd_rst_req}), 0);
      ctl_read(12'h000, d); chk("R9 ctrl after disable", 64'(d), 0);
      seen = 0;
      repeat (150) begin step(); seen = seen | wd_irq | wd_rst_req; end
      chk("R9 frozen while disabled", 64'(seen), 0);
      ctl_read(12'h000, d); chk("R9 no flags while disabled", 64'(d), 0);
      ctl_write(12'h000, 32'h1, at);
      chk_due("R5 re-enable deadline", at + 64'd50);
   endtask

   initial begin
      #100_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_unmapped_ro();
      t_two_stage();
      t_refresh();
      t_interval_restart();
      t_disable();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule